// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block is a processor-side synchronous serial port with independent transmit and receive paths. Software talks to it through a small register port: it writes outgoing words into a transmit holding buffer and collects incoming words from a receive holding buffer. Behind each buffer sits a shift register, so one word can be queued while another is on the wire. On the serial side each direction has a data clock, a frame-sync and a data pin. The transmit clock and transmit frame-sync can either be produced inside the block, with the clock taken from a programmable divider of the system clock, or be taken from outside. The receive clock and receive frame-sync always come from outside.

The two ready flags are the flow control. Software may write the transmit buffer only while transmit-ready is set. Receive-ready tells software that a word is waiting. While that word stays unread the receiver will not accept another one: a word that completes meanwhile is parked in the shift register, and every bit after it is dropped. The rising edge of each ready flag can raise an interrupt, but only when both the port's own enable bit and the matching CPU-side enable input are set. All serial inputs are synchronised to the system clock, and their edges are detected there. Data goes out most significant bit first. Transmit data changes on rising serial-clock edges and receive data is sampled on falling edges.

Register map on `reg_addr`: 0 = CTRL (read/write), 1 = TXBUF (write loads the transmit holding buffer), 2 = RXBUF (a read with `reg_rd` returns the receive holding buffer and consumes it), 3 = STAT (read flags, write 1 to clear interrupt flags).

Top module: `dbsp_port`

## Requirements
- R1: After reset CTRL reads 32'h0003_000F (word length field 15, divider 3, all mode and enable bits 0). STAT reads 32'h1 (bit0 transmit-ready = 1, bit1 receive-ready = 0, bit2 transmit interrupt flag = 0, bit3 receive interrupt flag = 0). `irq_tx`, `irq_rx`, `dx`, `sclk_tx_oe` and `fs_tx_oe` are all 0.
- R2: A write to TXBUF clears transmit-ready. The holding word is copied into the transmit shift register only while that register is empty, and transmit-ready is set again in the cycle of the copy. A word written while another is shifting keeps transmit-ready at 0 until the earlier word has finished.
- R3: CTRL bits 4:0 hold the word length minus one. The transmitter sends the low (length) bits of the word, most significant bit first. Each bit is put on `dx` at a rising edge of the transmit clock.
- R4: With CTRL bit5 = 1 the transmit clock is internal. `sclk_tx_out` idles low, `sclk_tx_oe` is 1, and each level lasts (CTRL[23:16] + 1) system cycles. With CTRL bit6 = 1 the frame-sync is internal. `fs_tx_oe` is 1, and `fs_tx_out` goes high for exactly one serial-clock period that ends at the rising edge carrying the first data bit.
- R5: The receiver arms on a falling edge of `sclk_rx` that sees `fs_rx` high. It then samples `dr` on the next (length) falling edges. The word lands right-aligned and zero-extended in RXBUF, and receive-ready sets.
- R6: A read of RXBUF with `reg_rd` asserted clears receive-ready.
- R7: If receive-ready is still set when a word completes, RXBUF is not overwritten and the receiver freezes. Further serial input is ignored. After RXBUF is read, the parked word moves into RXBUF and receive-ready sets again. Bits that arrived while frozen are lost.
- R8: A rising edge of transmit-ready sets the transmit interrupt flag (STAT bit2, driven on `irq_tx`) only if CTRL bit7 and `cpu_tx_ie` are both 1. Writing STAT with bit2 = 1 clears it.
- R9: A rising edge of receive-ready sets the receive interrupt flag (STAT bit3, driven on `irq_rx`) only if CTRL bit8 and `cpu_rx_ie` are both 1. Writing STAT with bit3 = 1 clears it.
- R10: With CTRL bit5 = 0 and bit6 = 0, `sclk_tx_oe` and `fs_tx_oe` are 0. The transmitter then shifts on rising edges of `sclk_tx_in`, and it starts a word after a falling edge of `sclk_tx_in` that sees `fs_tx_in` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (consumes RXBUF) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| cpu_tx_ie | input | 1 | CPU-side transmit interrupt enable |
| cpu_rx_ie | input | 1 | CPU-side receive interrupt enable |
| irq_tx | output | 1 | Transmit interrupt flag |
| irq_rx | output | 1 | Receive interrupt flag |
| sclk_tx_in | input | 1 | External transmit clock |
| sclk_tx_out | output | 1 | Internally generated transmit clock |
| sclk_tx_oe | output | 1 | Transmit clock is driven by the block |
| fs_tx_in | input | 1 | External transmit frame-sync |
| fs_tx_out | output | 1 | Internally generated transmit frame-sync |
| fs_tx_oe | output | 1 | Transmit frame-sync is driven by the block |
| dx | output | 1 | Serial transmit data |
| sclk_rx | input | 1 | Receive clock |
| fs_rx | input | 1 | Receive frame-sync |
| dr | input | 1 | Serial receive data |

## Verification
The bench builds the port with its default parameters: 32-bit words and an 8-bit divider field. It loops the transmit pins back to the receive pins. At run time it programs word lengths of 1, 5, 8, 12, 16, 24 and 32 bits and divider values from 1 to 5, which reaches the shortest and longest frames as well as masking of the bits above the word length. An external-clock run at a half period of 8 system cycles covers the path where the clock and frame-sync come from outside. Back-to-back words with RXBUF left unread drive the receiver into its frozen state and hold it there.

// File: rtl/dbsp_pkg.sv
package dbsp_pkg;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 8;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TXB  = 2'd1;
  localparam logic [1:0] A_RXB  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  localparam int DIV_POS = 16;
endpackage

// File: rtl/dbsp_sync.sv
module dbsp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end
  assign q = s2;
endmodule

// File: rtl/dbsp_clkdiv.sv
module dbsp_clkdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  output logic            sclk,
  output logic            rise,
  output logic            fall
);
  logic [DIVW-1:0] cnt;
  logic            tick;
  assign tick = en && (cnt >= div);
  assign rise = tick && !sclk;
  assign fall = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: the internal clock level only flips on a divider tick
  p_sclk_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && !tick && $past(en) |=> $stable(sclk));
endmodule

// File: rtl/dbsp_tx.sv
module dbsp_tx #(
  parameter int DW = 32,
  parameter int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          fall,
  input  logic          fs_int,
  input  logic          fs_ext,
  input  logic [LW-1:0] wlen_m1,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          empty,
  output logic          dx,
  output logic          fs_out
);
  logic [DW-1:0] sh;
  logic [LW-1:0] cnt, sa;
  logic          full, active, fs_seen, fs_q, dx_q;

  assign sa     = LW'(DW-1) - wlen_m1;
  assign empty  = !full;
  assign dx     = dx_q;
  assign fs_out = fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      full    <= 1'b0;
      active  <= 1'b0;
      fs_seen <= 1'b0;
      fs_q    <= 1'b0;
      dx_q    <= 1'b0;
    end else begin
      if (load) begin
        sh   <= load_data << sa;
        full <= 1'b1;
      end
      if (fall && full && !active && !fs_seen && (fs_int ? fs_q : fs_ext))
        fs_seen <= 1'b1;
      if (rise) begin
        if (fs_seen) begin
          fs_seen <= 1'b0;
          fs_q    <= 1'b0;
          active  <= 1'b1;
          dx_q    <= sh[DW-1];
          sh      <= sh << 1;
          cnt     <= wlen_m1;
        end else if (active) begin
          if (cnt == '0) begin
            active <= 1'b0;
            full   <= 1'b0;
          end else begin
            dx_q <= sh[DW-1];
            sh   <= sh << 1;
            cnt  <= cnt - 1'b1;
          end
        end else if (fs_int && full && !fs_q) begin
          fs_q <= 1'b1;
        end
      end
    end
  end

  // R2: the holding word is only copied into an empty shift register
  p_load_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !full);
  // R4: an internal frame pulse ends at the next rising serial edge
  p_fs_one_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fs_int && fs_q && rise |=> !fs_q);
  // R3: data only moves on a rising serial edge
  p_dx_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(dx_q));
endmodule

// File: rtl/dbsp_rx.sv
module dbsp_rx #(
  parameter int DW = 32,
  parameter int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          fs,
  input  logic          dr,
  input  logic [LW-1:0] wlen_m1,
  input  logic          hold_free,
  output logic          push,
  output logic [DW-1:0] word
);
  logic [DW-1:0] rsr, nxt;
  logic [LW-1:0] cnt;
  logic          sclk_d, fall, active, frozen;

  assign fall = sclk_d && !sclk;
  assign nxt  = {rsr[DW-2:0], dr};
  assign word = rsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsr    <= '0;
      cnt    <= '0;
      sclk_d <= 1'b0;
      active <= 1'b0;
      frozen <= 1'b0;
      push   <= 1'b0;
    end else begin
      sclk_d <= sclk;
      push   <= 1'b0;
      if (frozen) begin
        if (hold_free) begin
          push   <= 1'b1;
          frozen <= 1'b0;
        end
      end else if (fall) begin
        if (!active) begin
          if (fs) begin
            active <= 1'b1;
            cnt    <= '0;
            rsr    <= '0;
          end
        end else begin
          rsr <= nxt;
          if (cnt == wlen_m1) begin
            active <= 1'b0;
            if (hold_free) push <= 1'b1;
            else           frozen <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R7: a parked word stays parked until the holding buffer is free
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !hold_free |=> frozen && $stable(rsr));
  // R7: a word is never pushed into an occupied holding buffer
  p_push_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(hold_free));
endmodule

// File: rtl/dbsp_port.sv
module dbsp_port
  import dbsp_pkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int DIVW     = DIV_W,
  parameter int RST_WLEN = 15,
  parameter int RST_DIV  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          cpu_tx_ie,
  input  logic          cpu_rx_ie,
  output logic          irq_tx,
  output logic          irq_rx,
  input  logic          sclk_tx_in,
  output logic          sclk_tx_out,
  output logic          sclk_tx_oe,
  input  logic          fs_tx_in,
  output logic          fs_tx_out,
  output logic          fs_tx_oe,
  output logic          dx,
  input  logic          sclk_rx,
  input  logic          fs_rx,
  input  logic          dr
);
  localparam int LW     = $clog2(DW);
  localparam int B_CLK  = LW;
  localparam int B_FS   = LW + 1;
  localparam int B_TXIE = LW + 2;
  localparam int B_RXIE = LW + 3;

  logic [LW-1:0]   c_wlen;
  logic [DIVW-1:0] c_div;
  logic            c_clk_int, c_fs_int, c_tx_ie, c_rx_ie;
  logic [DW-1:0]   tx_hold, rx_hold, rx_word, ctrl_rd;
  logic            tx_rdy, rx_rdy, tx_rdy_d, rx_rdy_d, tx_flag, rx_flag;
  logic            wr_ctrl, wr_txb, wr_stat, rd_rxb, tx_load, tx_empty, rx_push;
  logic            dv_sclk, dv_rise, dv_fall, ext_sclk_d, ext_rise, ext_fall;
  logic            tx_rise, tx_fall;
  logic [1:0]      ext_q;
  logic [2:0]      rx_q;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_txb  = reg_wr && (reg_addr == A_TXB);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign rd_rxb  = reg_rd && (reg_addr == A_RXB);
  assign tx_load = !tx_rdy && tx_empty && !wr_txb;

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_wlen    <= LW'(RST_WLEN);
      c_div     <= DIVW'(RST_DIV);
      c_clk_int <= 1'b0;
      c_fs_int  <= 1'b0;
      c_tx_ie   <= 1'b0;
      c_rx_ie   <= 1'b0;
    end else if (wr_ctrl) begin
      c_wlen    <= reg_wdata[LW-1:0];
      c_div     <= reg_wdata[DIV_POS +: DIVW];
      c_clk_int <= reg_wdata[B_CLK];
      c_fs_int  <= reg_wdata[B_FS];
      c_tx_ie   <= reg_wdata[B_TXIE];
      c_rx_ie   <= reg_wdata[B_RXIE];
    end
  end

  // holding buffers, ready flags, interrupt flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold  <= '0;
      rx_hold  <= '0;
      tx_rdy   <= 1'b1;
      rx_rdy   <= 1'b0;
      tx_rdy_d <= 1'b1;
      rx_rdy_d <= 1'b0;
      tx_flag  <= 1'b0;
      rx_flag  <= 1'b0;
    end else begin
      tx_rdy_d <= tx_rdy;
      rx_rdy_d <= rx_rdy;
      if (wr_txb) begin
        tx_hold <= reg_wdata;
        tx_rdy  <= 1'b0;
      end else if (tx_load) begin
        tx_rdy  <= 1'b1;
      end
      if (rx_push) begin
        rx_hold <= rx_word;
        rx_rdy  <= 1'b1;
      end else if (rd_rxb) begin
        rx_rdy  <= 1'b0;
      end
      if (tx_rdy && !tx_rdy_d && c_tx_ie && cpu_tx_ie) tx_flag <= 1'b1;
      else if (wr_stat && reg_wdata[2])                tx_flag <= 1'b0;
      if (rx_rdy && !rx_rdy_d && c_rx_ie && cpu_rx_ie) rx_flag <= 1'b1;
      else if (wr_stat && reg_wdata[3])                rx_flag <= 1'b0;
    end
  end

  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[LW-1:0]             = c_wlen;
    ctrl_rd[B_CLK]              = c_clk_int;
    ctrl_rd[B_FS]               = c_fs_int;
    ctrl_rd[B_TXIE]             = c_tx_ie;
    ctrl_rd[B_RXIE]             = c_rx_ie;
    ctrl_rd[DIV_POS +: DIVW]    = c_div;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_rd;
      A_TXB:   reg_rdata = tx_hold;
      A_RXB:   reg_rdata = rx_hold;
      default: reg_rdata = {{(DW-4){1'b0}}, rx_flag, tx_flag, rx_rdy, tx_rdy};
    endcase
  end

  assign irq_tx = tx_flag;
  assign irq_rx = rx_flag;

  // transmit clock source
  dbsp_clkdiv #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .en(c_clk_int), .div(c_div),
    .sclk(dv_sclk), .rise(dv_rise), .fall(dv_fall)
  );

  dbsp_sync #(.W(2)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d({fs_tx_in, sclk_tx_in}), .q(ext_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sclk_d <= 1'b0;
    else        ext_sclk_d <= ext_q[0];
  end
  assign ext_rise = ext_q[0] && !ext_sclk_d;
  assign ext_fall = !ext_q[0] && ext_sclk_d;
  assign tx_rise  = c_clk_int ? dv_rise : ext_rise;
  assign tx_fall  = c_clk_int ? dv_fall : ext_fall;

  assign sclk_tx_out = dv_sclk;
  assign sclk_tx_oe  = c_clk_int;
  assign fs_tx_oe    = c_fs_int;

  dbsp_tx #(.DW(DW), .LW(LW)) u_tx (
    .clk(clk), .rst_n(rst_n), .rise(tx_rise), .fall(tx_fall),
    .fs_int(c_fs_int), .fs_ext(ext_q[1]), .wlen_m1(c_wlen),
    .load(tx_load), .load_data(tx_hold), .empty(tx_empty),
    .dx(dx), .fs_out(fs_tx_out)
  );

  dbsp_sync #(.W(3)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d({dr, fs_rx, sclk_rx}), .q(rx_q)
  );

  dbsp_rx #(.DW(DW), .LW(LW)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(rx_q[0]), .fs(rx_q[1]), .dr(rx_q[2]),
    .wlen_m1(c_wlen), .hold_free(!rx_rdy), .push(rx_push), .word(rx_word)
  );

  // R7: an unread receive word is never overwritten
  p_rxhold_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy && !rd_rxb |=> rx_rdy && $stable(rx_hold));
  // R2: transmit-ready only rises when the shift register was empty
  p_txrdy_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_rdy) |-> $past(tx_empty));
  // R8: transmit interrupt needs both enables
  p_txirq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> $past(c_tx_ie && cpu_tx_ie && tx_rdy));
  // R9: receive interrupt needs both enables
  p_rxirq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(c_rx_ie && cpu_rx_ie && rx_rdy));
endmodule

// File: tb/dbsp_port_tb.sv
module dbsp_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_tx_ie = 1'b0, cpu_rx_ie = 1'b0;
  logic        irq_tx, irq_rx;
  logic        ext_sclk = 1'b0, ext_fs = 1'b0;
  logic        sclk_tx_out, sclk_tx_oe, fs_tx_out, fs_tx_oe, dx;
  logic        sclk_rx, fs_rx;
  int          total = 0, bad = 0;

  localparam logic [1:0] CTRL = 2'd0, TXB = 2'd1, RXB = 2'd2, STAT = 2'd3;

  always #10 clk = ~clk;

  assign sclk_rx = sclk_tx_oe ? sclk_tx_out : ext_sclk;
  assign fs_rx   = fs_tx_oe   ? fs_tx_out   : ext_fs;

  dbsp_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_tx_ie(cpu_tx_ie), .cpu_rx_ie(cpu_rx_ie), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .sclk_tx_in(ext_sclk), .sclk_tx_out(sclk_tx_out), .sclk_tx_oe(sclk_tx_oe),
    .fs_tx_in(ext_fs), .fs_tx_out(fs_tx_out), .fs_tx_oe(fs_tx_oe), .dx(dx),
    .sclk_rx(sclk_rx), .fs_rx(fs_rx), .dr(dx)
  );

  // {wlen-1, divider, word written, word expected back}
  localparam logic [76:0] VEC [8] = '{
    {5'd15, 8'd3, 32'h0000_ABCD, 32'h0000_ABCD},
    {5'd15, 8'd2, 32'hFFFF_1234, 32'h0000_1234},
    {5'd7,  8'd1, 32'h0000_01C1, 32'h0000_00C1},
    {5'd31, 8'd1, 32'h8000_0001, 32'h8000_0001},
    {5'd0,  8'd3, 32'h0000_0001, 32'h0000_0001},
    {5'd11, 8'd4, 32'h0000_0FFF, 32'h0000_0FFF},
    {5'd4,  8'd2, 32'h0000_003B, 32'h0000_001B},
    {5'd23, 8'd5, 32'h00A5_5A0F, 32'h00A5_5A0F}
  };

  // independent decoder of the transmit pins (internal clock mode)
  int          mon_len = 16, mon_n = 0;
  logic        mon_act = 1'b0, sclk_prev = 1'b0;
  logic [31:0] mon_w = '0, mon_word = '0;
  int          fs_run = 0, fs_len = 0, hi_run = 0, hi_len = 0;
  always @(posedge clk) begin
    sclk_prev <= sclk_tx_out;
    if (sclk_prev && !sclk_tx_out) begin
      if (!mon_act) begin
        if (fs_tx_out) begin mon_act <= 1'b1; mon_n <= 0; mon_w <= '0; end
      end else begin
        mon_w <= {mon_w[30:0], dx};
        if (mon_n + 1 == mon_len) begin
          mon_act  <= 1'b0;
          mon_word <= {mon_w[30:0], dx};
        end else mon_n <= mon_n + 1;
      end
    end
    if (fs_tx_out) fs_run <= fs_run + 1;
    else if (fs_run != 0) begin fs_len <= fs_run; fs_run <= 0; end
    if (sclk_tx_out) hi_run <= hi_run + 1;
    else if (hi_run != 0) begin hi_len <= hi_run; hi_run <= 0; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = STAT;
  endtask

  task automatic wait_stat(input int b, input logic v, input int maxc);
    logic [31:0] s;
    for (int i = 0; i < maxc; i++) begin
      rd(STAT, s);
      if (s[b] === v) return;
    end
  endtask

  function automatic logic [31:0] cw(input int wl, input int dv, input bit ci,
                                     input bit fi, input bit ti, input bit ri);
    return (32'(dv) << 16) | (32'(ri) << 8) | (32'(ti) << 7) | (32'(fi) << 6)
         | (32'(ci) << 5) | 32'(wl);
  endfunction

  task automatic ext_frame(input int nbits);
    ext_fs = 1'b1;
    repeat (8) @(negedge clk); ext_sclk = 1'b1;
    repeat (8) @(negedge clk); ext_sclk = 1'b0;
    repeat (4) @(negedge clk); ext_fs = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits + 2; i++) begin
      ext_sclk = 1'b1; repeat (8) @(negedge clk);
      ext_sclk = 1'b0; repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(CTRL, v); check("R1 ctrl", v, 32'h0003_000F);
    rd(STAT, v); check("R1 stat", v, 32'h1);
    check("R1 pins", {27'd0, irq_tx, irq_rx, dx, sclk_tx_oe, fs_tx_oe}, 32'h0);

    // R3 R5 R6: table walk in internal clock, internal frame mode
    for (int i = 0; i < 8; i++) begin
      logic [76:0] e;
      e = VEC[i];
      wr(CTRL, cw(int'(e[76:72]), int'(e[71:64]), 1'b1, 1'b1, 1'b0, 1'b0));
      mon_len = int'(e[76:72]) + 1;
      wr(TXB, e[63:32]);
      wait_stat(1, 1'b1, 2000);
      rd(RXB, v); check("R5 rx word", v, e[31:0]);
      check("R3 msb-first on dx", mon_word, e[31:0]);
      rd(STAT, v); check("R6 rx-ready cleared", {31'd0, v[1]}, 32'd0);
    end

    // R4 clock level length and frame pulse width, divider 3
    wr(CTRL, cw(15, 3, 1'b1, 1'b1, 1'b0, 1'b0));
    check("R4 oe", {30'd0, sclk_tx_oe, fs_tx_oe}, 32'h3);
    wr(TXB, 32'h0000_5AA5);
    wait_stat(1, 1'b1, 2000);
    rd(RXB, v);
    check("R4 sclk high cycles", 32'(hi_len), 32'd4);
    check("R4 fs high cycles", 32'(fs_len), 32'd8);

    // R2 and R7: back-to-back words, receive buffer left unread
    wr(TXB, 32'h0000_1111);
    wait_stat(0, 1'b1, 50);
    wr(TXB, 32'h0000_2222);
    rd(STAT, v); check("R2 tx-ready low while busy", {31'd0, v[0]}, 32'd0);
    repeat (40) @(negedge clk);
    rd(STAT, v); check("R2 tx-ready still low", {31'd0, v[0]}, 32'd0);
    wait_stat(0, 1'b1, 2000);
    rd(STAT, v); check("R2 tx-ready after copy", {31'd0, v[0]}, 32'd1);
    wr(TXB, 32'h0000_3333);
    wait_stat(0, 1'b1, 2000);
    repeat (400) @(negedge clk);
    rd(STAT, v); check("R7 rx-ready held", {31'd0, v[1]}, 32'd1);
    rd(RXB, v);  check("R7 first word kept", v, 32'h0000_1111);
    repeat (3) @(negedge clk);
    rd(STAT, v); check("R7 parked word released", {31'd0, v[1]}, 32'd1);
    rd(RXB, v);  check("R7 parked word value", v, 32'h0000_2222);
    repeat (400) @(negedge clk);
    rd(STAT, v); check("R7 bits while frozen dropped", {31'd0, v[1]}, 32'd0);

    // R8 transmit interrupt gating and clear
    wr(CTRL, cw(7, 2, 1'b1, 1'b1, 1'b1, 1'b0));
    cpu_tx_ie = 1'b1;
    wr(STAT, 32'hC);
    wr(TXB, 32'h0000_0042);
    wait_stat(1, 1'b1, 2000);
    rd(RXB, v);
    check("R8 tx irq set", {31'd0, irq_tx}, 32'd1);
    wr(STAT, 32'h4);
    check("R8 tx irq cleared", {31'd0, irq_tx}, 32'd0);
    cpu_tx_ie = 1'b0;
    wr(TXB, 32'h0000_0043);
    wait_stat(1, 1'b1, 2000);
    rd(RXB, v);
    check("R8 tx irq blocked by cpu enable", {31'd0, irq_tx}, 32'd0);

    // R9 receive interrupt gating and clear
    wr(CTRL, cw(7, 2, 1'b1, 1'b1, 1'b0, 1'b1));
    cpu_rx_ie = 1'b1;
    wr(TXB, 32'h0000_0081);
    wait_stat(1, 1'b1, 2000);
    repeat (2) @(negedge clk);
    check("R9 rx irq set", {31'd0, irq_rx}, 32'd1);
    rd(RXB, v);
    wr(STAT, 32'h8);
    check("R9 rx irq cleared", {31'd0, irq_rx}, 32'd0);
    wr(CTRL, cw(7, 2, 1'b1, 1'b1, 1'b0, 1'b0));
    wr(TXB, 32'h0000_0082);
    wait_stat(1, 1'b1, 2000);
    repeat (2) @(negedge clk);
    check("R9 rx irq blocked by port enable", {31'd0, irq_rx}, 32'd0);
    rd(RXB, v);

    // R10 external clock and frame-sync
    wr(CTRL, cw(7, 3, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R10 oe low", {30'd0, sclk_tx_oe, fs_tx_oe}, 32'h0);
    wr(TXB, 32'h0000_005E);
    repeat (4) @(negedge clk);
    ext_frame(8);
    wait_stat(1, 1'b1, 50);
    rd(RXB, v); check("R10 external word", v, 32'h0000_005E);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule